// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block holds a small bank of comparator slots that watch the processor's access stream and request a debug halt when a programmed condition is met. Each cycle one access is presented: its kind (instruction fetch, data read or data write), its size, its address and its data. A slot can match one address exactly, match an address under a don't-care mask, or join with its odd neighbour to match an inclusive address window. It can be limited to certain access kinds. It can be further qualified by a data value that is compared only over the byte lanes of the access size. The data test can be negated, and the address test can be inverted so that the slot fires outside its region.

Slots are programmed one field at a time through a write port. A per-slot countdown lets the Nth qualifying access raise the halt instead of the first. The running count cannot be observed from outside. A slot may also clear its own enable when it fires. The halt request is registered and stays high until the debugger acknowledges it. For fetch matches, a combinational early-stop output is also raised in the cycle of the access. This lets the core hold back the instruction before it executes.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset every slot is disabled: halt_req and hit_status are 0, and no access raises anything until a slot is programmed. Field select cfg_sel: 0 address, 1 mask, 2 data value, 3 control, 4 hit count.
- R2: Control bit 0 enables a slot. With control bits [4:3]=00, the slot matches when acc_addr equals its address.
- R3: Control bits [2:1] select the kind: 00 fetch, 01 read, 10 write, 11 read or write. acc_kind uses 00 fetch, 01 read, 10 write, and 11 is never matched.
- R4: With bits [4:3]=10 on an even slot, that slot matches start<=acc_addr<=end. Its own address is the start and the next odd slot's address is the end. The odd slot then never fires by itself.
- R5: With bits [4:3]=01, address bits set in the mask register are ignored in the compare.
- R6: Control bit 6 adds a data test over the lanes chosen by acc_size: 00 byte [7:0], 01 halfword [15:0], 1x full word.
- R7: Control bit 7 negates the data test.
- R8: Control bit 5 inverts the address test, so the slot fires for addresses outside its region.
- R9: A hit count N written through field 4 makes only every Nth qualifying access fire; the count then restarts. N of 0 or 1 fires on every access.
- R10: Control bit 8 clears the slot's enable when the slot fires.
- R11: A firing sets halt_req and the slot's hit_status bit one cycle later. Both hold until dbg_ack, which clears them unless a new firing happens in the same cycle.
- R12: stop_now is high in the same cycle as a firing fetch access and is never high for read or write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SW | Slot written |
| cfg_sel | input | 3 | Field written |
| cfg_wdata | input | AW | Write value |
| acc_valid | input | 1 | An access is presented |
| acc_kind | input | 2 | Access kind |
| acc_size | input | 2 | Access size |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data, right-aligned |
| dbg_ack | input | 1 | Debugger acknowledge |
| halt_req | output | 1 | Registered halt request |
| stop_now | output | 1 | Same-cycle fetch stop |
| hit_status | output | NSLOT | Slots that fired since last acknowledge |

## Verification
stop_now depends only on the present access and the slot state, so it is due in the same cycle. halt_req, hit_status, count progress, auto-disable and configuration writes take effect one edge after the cycle that causes them. The bench steps a behavioural model at each rising edge and compares all outputs 1 ns later, while the inputs for that cycle are still applied. That sample point sees both the registered results of the edge just taken and the combinational early stop for the held access. Directed checks sample halt state at the falling edge after an access, and early-stop state before the edge that captures it.

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NSLOT = 4,
  parameter int CW = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [1:0]       acc_size,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_data,
  input  logic             dbg_ack,
  output logic             halt_req,
  output logic             stop_now,
  output logic [NSLOT-1:0] hit_status
);
  localparam int CTLW = 9;

  logic [AW-1:0]   a_q [NSLOT];
  logic [AW-1:0]   m_q [NSLOT];
  logic [DW-1:0]   d_q [NSLOT];
  logic [CTLW-1:0] c_q [NSLOT];
  logic [CW-1:0]   r_q [NSLOT];
  logic [CW-1:0]   n_q [NSLOT];
  logic [NSLOT-1:0] raw, fire, hit_q;
  logic halt_q;
  logic [DW-1:0] lanes;

  assign lanes = (acc_size == 2'b00) ? DW'(8'hFF) :
                 (acc_size == 2'b01) ? DW'(16'hFFFF) : '1;

  for (genvar g = 0; g < NSLOT; g++) begin : slot
    logic kind_ok, data_eq, data_ok, exact, masked, in_rng, addr_raw, paired_off;
    logic [1:0] mode;

    assign mode    = c_q[g][4:3];
    assign kind_ok = acc_kind != 2'b11 &&
                     (c_q[g][2:1] == acc_kind ||
                      (c_q[g][2:1] == 2'b11 && acc_kind != 2'b00));
    assign data_eq = ((acc_data ^ d_q[g]) & lanes) == '0;
    assign data_ok = !c_q[g][6] || (data_eq ^ c_q[g][7]);
    assign exact   = acc_addr == a_q[g];
    assign masked  = ((acc_addr ^ a_q[g]) & ~m_q[g]) == '0;

    if (g % 2 == 0 && g + 1 < NSLOT) begin : g_rng
      assign in_rng = acc_addr >= a_q[g] && acc_addr <= a_q[g+1];
    end else begin : g_norng
      assign in_rng = exact;
    end

    if (g % 2 == 1) begin : g_odd
      assign paired_off = c_q[g-1][4:3] == 2'b10;
    end else begin : g_even
      assign paired_off = 1'b0;
    end

    assign addr_raw = (mode == 2'b01) ? masked : (mode == 2'b10) ? in_rng : exact;
    assign raw[g]   = acc_valid && c_q[g][0] && kind_ok && data_ok &&
                      (addr_raw ^ c_q[g][5]) && !paired_off;
    assign fire[g]  = raw[g] && n_q[g] <= CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[g] <= '0;
        m_q[g] <= '0;
        d_q[g] <= '0;
        c_q[g] <= '0;
        r_q[g] <= '0;
        n_q[g] <= '0;
      end else begin
        if (raw[g])
          n_q[g] <= (n_q[g] <= CW'(1)) ? r_q[g] : n_q[g] - CW'(1);
        if (fire[g] && c_q[g][8])
          c_q[g][0] <= 1'b0;
        if (cfg_we && cfg_slot == SW'(g)) begin
          case (cfg_sel)
            3'd0: a_q[g] <= cfg_wdata;
            3'd1: m_q[g] <= cfg_wdata;
            3'd2: d_q[g] <= cfg_wdata[DW-1:0];
            3'd3: c_q[g] <= cfg_wdata[CTLW-1:0];
            3'd4: begin
              r_q[g] <= cfg_wdata[CW-1:0];
              n_q[g] <= cfg_wdata[CW-1:0];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      hit_q  <= (dbg_ack ? '0 : hit_q) | fire;
      halt_q <= (halt_q && !dbg_ack) || |fire;
    end
  end

  assign stop_now   = acc_kind == 2'b00 && |fire;
  assign halt_req   = halt_q;
  assign hit_status = hit_q;
endmodule

module dbg_watch_unit_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [1:0]       acc_kind,
  input logic             dbg_ack,
  input logic             halt_req,
  input logic             stop_now,
  input logic [NSLOT-1:0] hit_status,
  input logic [NSLOT-1:0] fire
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> fire == '0);
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !dbg_ack |=> halt_req);
  p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ack && fire == '0 |=> !halt_req && hit_status == '0);
  p_halt_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(|fire));
  p_hit_implies_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    |hit_status |-> halt_req);
  p_stop_fetch_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |-> acc_valid && acc_kind == 2'b00);
  p_stop_then_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> halt_req);
endmodule

bind dbg_watch_unit dbg_watch_unit_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
  .dbg_ack(dbg_ack), .halt_req(halt_req), .stop_now(stop_now),
  .hit_status(hit_status), .fire(fire)
);

// File: tb/dbg_watch_unit_tb.sv
module dbg_watch_unit_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_slot = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic acc_valid = 0;
  logic [1:0] acc_kind = 0, acc_size = 0;
  logic [31:0] acc_addr = 0, acc_data = 0;
  logic dbg_ack = 0;
  logic halt_req, stop_now;
  logic [3:0] hit_status;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  dbg_watch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_size(acc_size), .acc_addr(acc_addr),
    .acc_data(acc_data), .dbg_ack(dbg_ack), .halt_req(halt_req),
    .stop_now(stop_now), .hit_status(hit_status)
  );

  always #5 clk = ~clk;

  logic [31:0] ma[4], mm[4], md[4];
  logic [8:0]  mc[4];
  logic [7:0]  mr[4], mn[4];
  logic [3:0]  mhit;
  logic        mhalt;
  bit rw[4], fw[4];

  function automatic bit mraw(int i);
    bit tok, aok, dok;
    logic [31:0] lm;
    if (!acc_valid || !mc[i][0]) return 0;
    if (i % 2 == 1 && mc[i-1][4:3] == 2'b10) return 0;
    case (mc[i][2:1])
      2'd0: tok = acc_kind == 0;
      2'd1: tok = acc_kind == 1;
      2'd2: tok = acc_kind == 2;
      default: tok = acc_kind == 1 || acc_kind == 2;
    endcase
    lm = acc_size == 0 ? 32'hFF : acc_size == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
    if (mc[i][4:3] == 2'b01) aok = (acc_addr & ~mm[i]) == (ma[i] & ~mm[i]);
    else if (mc[i][4:3] == 2'b10 && i % 2 == 0) aok = acc_addr >= ma[i] && acc_addr <= ma[i+1];
    else aok = acc_addr == ma[i];
    if (mc[i][5]) aok = !aok;
    dok = 1;
    if (mc[i][6]) begin
      dok = (acc_data & lm) == (md[i] & lm);
      if (mc[i][7]) dok = !dok;
    end
    return tok && aok && dok;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit any, es;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        ma[i] = 0; mm[i] = 0; md[i] = 0; mc[i] = 0; mr[i] = 0; mn[i] = 0;
      end
      mhit = 0; mhalt = 0;
    end else begin
      any = 0;
      for (int i = 0; i < 4; i++) begin
        rw[i] = mraw(i);
        fw[i] = rw[i] && mn[i] <= 1;
        any |= fw[i];
      end
      for (int i = 0; i < 4; i++) begin
        if (rw[i]) mn[i] = (mn[i] <= 1) ? mr[i] : mn[i] - 1;
        if (fw[i] && mc[i][8]) mc[i][0] = 0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          0: ma[cfg_slot] = cfg_wdata;
          1: mm[cfg_slot] = cfg_wdata;
          2: md[cfg_slot] = cfg_wdata;
          3: mc[cfg_slot] = cfg_wdata[8:0];
          4: begin mr[cfg_slot] = cfg_wdata[7:0]; mn[cfg_slot] = cfg_wdata[7:0]; end
          default: ;
        endcase
      end
      if (dbg_ack) mhit = 0;
      for (int i = 0; i < 4; i++) if (fw[i]) mhit[i] = 1;
      mhalt = (mhalt && !dbg_ack) || any;
    end
    #1;
    if (rst_n && !done) begin
      es = 0;
      for (int i = 0; i < 4; i++) if (mraw(i) && mn[i] <= 1 && acc_kind == 0) es = 1;
      check(cur_req, "model halt_req", halt_req, mhalt);
      check(cur_req, "model hit_status", hit_status, mhit);
      check(cur_req, "model stop_now", stop_now, es);
    end
  end

  task automatic cfg(int s, int sel, logic [31:0] v);
    cfg_we = 1; cfg_slot = s[1:0]; cfg_sel = sel[2:0]; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(int k, int sz, logic [31:0] a, logic [31:0] d);
    acc_valid = 1; acc_kind = k[1:0]; acc_size = sz[1:0]; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 0; acc_kind = 2'b11;
  endtask

  task automatic ack();
    dbg_ack = 1;
    @(negedge clk);
    dbg_ack = 0;
  endtask

  task automatic expect_hit(string req, logic [3:0] hits);
    check(req, "halt_req", halt_req, hits != 0);
    check(req, "hit_status", hit_status, hits);
    if (hits != 0) ack();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    acc_kind = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "halt after reset", halt_req, 0);
    check("R1", "hits after reset", hit_status, 0);
    acc(0, 2, 32'h0, 0); acc(1, 2, 32'h0, 0); acc(2, 2, 32'h0, 0);
    expect_hit("R1", 4'b0000);

    cur_req = "R2";
    cfg(0, 0, 32'h100); cfg(0, 3, 32'h001);
    acc(0, 2, 32'h104, 0); expect_hit("R2", 4'b0000);
    acc(0, 2, 32'h100, 0); expect_hit("R2", 4'b0001);

    cur_req = "R3";
    acc(1, 2, 32'h100, 0); expect_hit("R3", 4'b0000);
    cfg(1, 0, 32'h300); cfg(1, 3, 32'h007);
    acc(0, 2, 32'h300, 0); expect_hit("R3", 4'b0000);
    acc(1, 2, 32'h300, 0); expect_hit("R3", 4'b0010);
    acc(2, 2, 32'h300, 0); expect_hit("R3", 4'b0010);
    acc(3, 2, 32'h300, 0); expect_hit("R3", 4'b0000);

    cur_req = "R4";
    cfg(2, 0, 32'h200); cfg(3, 0, 32'h20F);
    cfg(3, 3, 32'h007); cfg(2, 3, 32'h017);
    acc(1, 2, 32'h20F, 0); expect_hit("R4", 4'b0100);
    acc(1, 2, 32'h200, 0); expect_hit("R4", 4'b0100);
    acc(2, 2, 32'h207, 0); expect_hit("R4", 4'b0100);
    acc(1, 2, 32'h210, 0); expect_hit("R4", 4'b0000);
    acc(1, 2, 32'h1FF, 0); expect_hit("R4", 4'b0000);
    cfg(2, 3, 32'h000);
    acc(1, 2, 32'h20F, 0); expect_hit("R4", 4'b1000);
    cfg(3, 3, 32'h000);

    cur_req = "R5";
    cfg(1, 0, 32'h400); cfg(1, 1, 32'h00F); cfg(1, 3, 32'h00F);
    acc(1, 2, 32'h40C, 0); expect_hit("R5", 4'b0010);
    acc(1, 2, 32'h410, 0); expect_hit("R5", 4'b0000);

    cur_req = "R8";
    cfg(1, 0, 32'h500); cfg(1, 3, 32'h027);
    acc(1, 2, 32'h500, 0); expect_hit("R8", 4'b0000);
    acc(1, 2, 32'h504, 0); expect_hit("R8", 4'b0010);
    cfg(1, 3, 32'h000);

    cur_req = "R6";
    cfg(2, 0, 32'h600); cfg(2, 2, 32'h5A); cfg(2, 3, 32'h045);
    acc(2, 0, 32'h600, 32'hFFFF_FF5A); expect_hit("R6", 4'b0100);
    acc(2, 2, 32'h600, 32'hFFFF_FF5A); expect_hit("R6", 4'b0000);
    acc(2, 1, 32'h600, 32'hAB00_005A); expect_hit("R6", 4'b0100);
    acc(2, 1, 32'h600, 32'h0000_015A); expect_hit("R6", 4'b0000);

    cur_req = "R7";
    cfg(2, 3, 32'h0C5);
    acc(2, 0, 32'h600, 32'h5A); expect_hit("R7", 4'b0000);
    acc(2, 0, 32'h600, 32'h5B); expect_hit("R7", 4'b0100);
    cfg(2, 3, 32'h000);

    cur_req = "R9";
    cfg(3, 0, 32'h700); cfg(3, 4, 32'd3); cfg(3, 3, 32'h007);
    acc(1, 2, 32'h700, 0); expect_hit("R9", 4'b0000);
    acc(1, 2, 32'h700, 0); expect_hit("R9", 4'b0000);
    acc(1, 2, 32'h700, 0); expect_hit("R9", 4'b1000);
    acc(1, 2, 32'h700, 0); expect_hit("R9", 4'b0000);
    acc(2, 2, 32'h700, 0); expect_hit("R9", 4'b0000);
    acc(1, 2, 32'h700, 0); expect_hit("R9", 4'b1000);

    cur_req = "R10";
    cfg(3, 4, 32'd1); cfg(3, 3, 32'h107);
    acc(1, 2, 32'h700, 0); expect_hit("R10", 4'b1000);
    acc(1, 2, 32'h700, 0); expect_hit("R10", 4'b0000);

    cur_req = "R11";
    cfg(1, 0, 32'h800); cfg(1, 3, 32'h003);
    acc(1, 2, 32'h800, 0);
    repeat (4) @(negedge clk);
    check("R11", "halt held", halt_req, 1);
    check("R11", "hit held", hit_status, 4'b0010);
    dbg_ack = 1;
    acc(1, 2, 32'h800, 0);
    dbg_ack = 0;
    check("R11", "fire beats ack halt", halt_req, 1);
    check("R11", "fire beats ack hit", hit_status, 4'b0010);
    ack();
    check("R11", "ack clears halt", halt_req, 0);
    check("R11", "ack clears hit", hit_status, 0);

    cur_req = "R12";
    acc_valid = 1; acc_kind = 0; acc_size = 2; acc_addr = 32'h100;
    #1;
    check("R12", "early stop on fetch", stop_now, 1);
    check("R12", "halt not yet", halt_req, 0);
    @(negedge clk);
    acc_valid = 0; acc_kind = 2'b11;
    check("R12", "halt after fetch", halt_req, 1);
    ack();
    acc_valid = 1; acc_kind = 1; acc_addr = 32'h800;
    #1;
    check("R12", "no early stop on read", stop_now, 0);
    @(negedge clk);
    acc_valid = 0; acc_kind = 2'b11;
    check("R12", "read still halts", halt_req, 1);
    ack();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule